// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block sits on the controller side of a single-rank SDRAM interface. Its job is to make sure every row of the memory is refreshed within the refresh period. The device keeps its own row counter, so the scheduler only has to issue the right number of refresh commands at the right times, and each command must be issued separately. Before each refresh it closes any open bank with a precharge-all command. It then waits out the precharge time before the refresh goes out. After every refresh it keeps the bus quiet for the row-cycle time.

Two scheduling modes are available, chosen by `burst_mode`. In distributed mode one refresh becomes owed every `T_REF/REF_COUNT` cycles. In burst mode `REF_COUNT` refreshes become owed once per `T_REF` cycles and go out back to back at row-cycle spacing. A user access port competes for the bus through a request/grant handshake. In distributed mode a held request can defer owed refreshes until a postpone limit is reached. At that point the scheduler takes the bus and works off the whole backlog.

The controller is one state machine with five states. In `S_IDLE` the pins carry NOP, and a request can be granted. `S_PRE` drives precharge-all for one cycle. `S_RP_WAIT` drives NOP until the precharge time has run. `S_REF` drives the refresh command for one cycle. `S_RC_WAIT` drives NOP until the row-cycle time has run.

The transitions are:
- `S_IDLE` → `S_PRE` when a refresh is due and a bank is open.
- `S_IDLE` → `S_REF` when a refresh is due and all banks are closed.
- `S_PRE` → `S_RP_WAIT` always.
- `S_RP_WAIT` → `S_REF` when the wait counter expires.
- `S_REF` → `S_RC_WAIT` always.
- `S_RC_WAIT` → `S_REF` or `S_PRE` when the wait expires and another refresh is due.
- `S_RC_WAIT` → `S_IDLE` when the wait expires and nothing is due.

A refresh is "due" when one is owed and either no user request is present or the owed work is urgent. Owed work is urgent in burst mode, or once the postpone limit has been reached.

Top module: `ref_sched`

## Requirements
- R1: While `rst` is high, the pins carry NOP (`sdr_cs_n`=0, `sdr_ras_n`=1, `sdr_cas_n`=1, `sdr_we_n`=1), `sdr_cke`=1, `sdr_addr`=0 and `user_gnt`=0, even with `user_req` high.
- R2: A refresh command is `sdr_cs_n`=0, `sdr_ras_n`=0, `sdr_cas_n`=0, `sdr_we_n`=1 with `sdr_addr` all zero. `sdr_cke` is 1 in every cycle, and every cycle carries exactly one of NOP, precharge-all or refresh.
- R3: Precharge-all is `sdr_cs_n`=0, `sdr_ras_n`=0, `sdr_cas_n`=1, `sdr_we_n`=0 with only address bit `AP_BIT` (10) set. It precedes a refresh only when some `bank_open` bit is set; with all banks closed the refresh is issued without it.
- R4: A refresh follows its precharge-all exactly `T_RP` cycles later, with NOP in between.
- R5: In distributed mode one refresh becomes owed every `T_REF/REF_COUNT` cycles. With no user request, the first refresh appears `T_REF/REF_COUNT + 1` cycles after reset release, and later ones follow at exactly that spacing.
- R6: In burst mode `REF_COUNT` refreshes become owed once every `T_REF` cycles, and none become owed in between. They are issued consecutively exactly `T_RC` cycles apart, and the first appears `T_REF + 1` cycles after reset release.
- R7: `user_gnt` is high only while `user_req` is high and the scheduler is idle with no refresh due. It is low while precharge-all or refresh is driven, and it stays low until `T_RC` cycles after the last refresh.
- R8: While `user_req` is held in distributed mode, owed refreshes are deferred until `POSTPONE_MAX` (8) are owed. In the cycle the limit is reached the grant drops, and all owed refreshes are then issued `T_RC` apart before the grant returns.
- R9: When a held request is released with fewer than `POSTPONE_MAX` refreshes owed, the owed refreshes start in the next cycle and follow `T_RC` apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_mode | input | 1 | 1 selects burst refresh, 0 distributed |
| user_req | input | 1 | User access port requests the bus |
| bank_open | input | N_BANKS | Open-bank flags from the bank tracker |
| user_gnt | output | 1 | Bus granted to the user port |
| sdr_cke | output | 1 | Clock enable, held high |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W | Address pins; bit AP_BIT selects all banks on precharge |

## Verification
Two events can fall in the same cycle: the owed count reaching the postpone limit, and a user request that already holds the grant. The bench provokes this by holding `user_req` high from reset through eight distributed intervals. It then checks three things: the grant is still high in the cycle before the limit, it drops in the very cycle the eighth refresh becomes owed, and the first forced refresh follows one cycle later. The same collision is staged in burst mode, where the whole period's refreshes become owed in one cycle. There the bench checks that the request loses at once, rather than after a postpone limit.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_RP_WAIT,
        S_REF,
        S_RC_WAIT
    } sched_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/ref_interval_timer.sv
// Free-running interval counter; wraps at the distributed spacing or the
// full period, depending on the mode, and pulses tick in the wrap cycle.
module ref_interval_timer #(
    parameter int T_REF     = 8512000,
    parameter int REF_COUNT = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_mode,
    output logic tick
);
    localparam int CW    = $clog2(T_REF);
    localparam int LIM_D = T_REF / REF_COUNT - 1;
    localparam int LIM_B = T_REF - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = burst_mode ? CW'(LIM_B) : CW'(LIM_D);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/ref_owed_counter.sv
// Counts refreshes owed; adds one per interval (or a full period's worth in
// burst mode), subtracts one per issued refresh, and raises urgent when the
// backlog must be drained without yielding to the user port.
module ref_owed_counter #(
    parameter int REF_COUNT    = 8192,
    parameter int POSTPONE_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_mode,
    input  logic tick,
    input  logic issued,
    output logic owed_nz,
    output logic urgent
);
    localparam int OMAX = 2 * REF_COUNT + POSTPONE_MAX;
    localparam int OW   = $clog2(OMAX + 1);

    logic [OW-1:0] owed;
    logic [OW-1:0] owed_next;
    logic [OW-1:0] add;
    logic [OW:0]   sum;
    logic          drain_q;

    assign add = tick ? (burst_mode ? OW'(REF_COUNT) : OW'(1)) : '0;
    assign sum = {1'b0, owed} + {1'b0, add} - (OW+1)'(issued);

    always_comb begin
        if (sum > (OW+1)'(OMAX)) begin
            owed_next = OW'(OMAX);
        end else begin
            owed_next = sum[OW-1:0];
        end
    end

    assign owed_nz = (owed != '0);
    assign urgent  = owed_nz && (burst_mode || drain_q || (owed >= OW'(POSTPONE_MAX)));

    always_ff @(posedge clk) begin
        if (rst) begin
            owed    <= '0;
            drain_q <= 1'b0;
        end else begin
            owed    <= owed_next;
            drain_q <= urgent && (owed_next != '0);
        end
    end
endmodule

// File: rtl/ref_wait_timer.sv
// Down-counter for the precharge and row-cycle waits.
module ref_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!done) begin
            cnt <= cnt - W'(1);
        end
    end
endmodule

// File: rtl/ref_sched.sv
module ref_sched
    import ref_sched_pkg::*;
#(
    parameter int T_REF        = 8512000,
    parameter int REF_COUNT    = 8192,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int POSTPONE_MAX = 8,
    parameter int N_BANKS      = 4,
    parameter int ADDR_W       = 13,
    parameter int AP_BIT       = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               burst_mode,
    input  logic               user_req,
    input  logic [N_BANKS-1:0] bank_open,
    output logic               user_gnt,
    output logic               sdr_cke,
    output logic               sdr_cs_n,
    output logic               sdr_ras_n,
    output logic               sdr_cas_n,
    output logic               sdr_we_n,
    output logic [ADDR_W-1:0]  sdr_addr
);
    localparam int WMAX = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int WW   = $clog2(WMAX);

    sched_state_e state, state_next;
    sdr_cmd_t     cmd;

    logic          tick;
    logic          owed_nz;
    logic          urgent;
    logic          issued;
    logic          want_ref;
    logic          wait_done;
    logic          wait_load;
    logic [WW-1:0] wait_val;
    sched_state_e  entry;

    ref_interval_timer #(
        .T_REF     (T_REF),
        .REF_COUNT (REF_COUNT)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .burst_mode (burst_mode),
        .tick       (tick)
    );

    ref_owed_counter #(
        .REF_COUNT    (REF_COUNT),
        .POSTPONE_MAX (POSTPONE_MAX)
    ) u_owed (
        .clk        (clk),
        .rst        (rst),
        .burst_mode (burst_mode),
        .tick       (tick),
        .issued     (issued),
        .owed_nz    (owed_nz),
        .urgent     (urgent)
    );

    ref_wait_timer #(
        .W (WW)
    ) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    assign issued    = (state == S_REF);
    assign want_ref  = owed_nz && (urgent || !user_req);
    assign entry     = (|bank_open) ? S_PRE : S_REF;
    assign wait_load = (state == S_PRE) || (state == S_REF);
    assign wait_val  = (state == S_PRE) ? WW'(T_RP - 2) : WW'(T_RC - 2);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_next;
        end
    end

    // Next-state logic
    always_comb begin
        state_next = state;
        unique case (state)
            S_IDLE:    if (want_ref) state_next = entry;
            S_PRE:     state_next = S_RP_WAIT;
            S_RP_WAIT: if (wait_done) state_next = S_REF;
            S_REF:     state_next = S_RC_WAIT;
            S_RC_WAIT: if (wait_done) state_next = want_ref ? entry : S_IDLE;
            default:   state_next = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd      = CMD_NOP;
        sdr_addr = '0;
        unique case (state)
            S_PRE: begin
                cmd              = CMD_PRE;
                sdr_addr[AP_BIT] = 1'b1;
            end
            S_REF:   cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

    assign sdr_cke   = 1'b1;
    assign sdr_cs_n  = cmd.cs_n;
    assign sdr_ras_n = cmd.ras_n;
    assign sdr_cas_n = cmd.cas_n;
    assign sdr_we_n  = cmd.we_n;
    assign user_gnt  = !rst && (state == S_IDLE) && user_req && !want_ref;

endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
    parameter int T_RP    = 3,
    parameter int T_RC    = 9,
    parameter int N_BANKS = 4,
    parameter int ADDR_W  = 13,
    parameter int AP_BIT  = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               user_req,
    input logic               user_gnt,
    input logic [N_BANKS-1:0] bank_open,
    input logic               sdr_cke,
    input logic               sdr_cs_n,
    input logic               sdr_ras_n,
    input logic               sdr_cas_n,
    input logic               sdr_we_n,
    input logic [ADDR_W-1:0]  sdr_addr
);
    localparam int CAP = T_RP + T_RC + 1;
    localparam int SW  = $clog2(CAP + 1);

    logic is_nop, is_pre, is_ref;
    logic pre_seen, ref_seen;
    logic [SW-1:0] since_pre, since_ref;
    logic [ADDR_W-1:0] ap_mask;

    assign ap_mask = ADDR_W'(1) << AP_BIT;
    assign is_nop = !sdr_cs_n &&  sdr_ras_n &&  sdr_cas_n &&  sdr_we_n;
    assign is_pre = !sdr_cs_n && !sdr_ras_n &&  sdr_cas_n && !sdr_we_n;
    assign is_ref = !sdr_cs_n && !sdr_ras_n && !sdr_cas_n &&  sdr_we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_seen  <= 1'b0;
            ref_seen  <= 1'b0;
            since_pre <= '0;
            since_ref <= '0;
        end else begin
            if (is_pre) begin
                pre_seen  <= 1'b1;
                since_pre <= SW'(1);
            end else begin
                if (is_ref) pre_seen <= 1'b0;
                if (since_pre != SW'(CAP)) since_pre <= since_pre + SW'(1);
            end
            if (is_ref) begin
                ref_seen  <= 1'b1;
                since_ref <= SW'(1);
            end else if (since_ref != SW'(CAP)) begin
                since_ref <= since_ref + SW'(1);
            end
        end
    end

    p_cke_high_r2: assert property (@(posedge clk) disable iff (rst) sdr_cke);
    p_cmd_legal_r2: assert property (@(posedge clk) disable iff (rst) (is_nop || is_pre || is_ref));
    p_ref_addr_zero_r2: assert property (@(posedge clk) disable iff (rst) is_ref |-> (sdr_addr == '0));
    p_pre_all_bit_r3: assert property (@(posedge clk) disable iff (rst) is_pre |-> (sdr_addr == ap_mask));
    p_ref_banks_closed_r3: assert property (@(posedge clk) disable iff (rst) (is_ref && |bank_open) |-> pre_seen);
    p_rp_gap_r4: assert property (@(posedge clk) disable iff (rst) (is_ref && pre_seen) |-> (since_pre == SW'(T_RP)));
    p_rc_gap_r6: assert property (@(posedge clk) disable iff (rst) (is_ref && ref_seen) |-> (since_ref >= SW'(T_RC)));
    p_gnt_quiet_r7: assert property (@(posedge clk) disable iff (rst) (is_ref || is_pre) |-> !user_gnt);
    p_gnt_req_r7: assert property (@(posedge clk) disable iff (rst) user_gnt |-> user_req);
    p_gnt_after_rc_r7: assert property (@(posedge clk) disable iff (rst) (user_gnt && ref_seen) |-> (since_ref >= SW'(T_RC)));

endmodule

bind ref_sched ref_sched_chk #(
    .T_RP    (T_RP),
    .T_RC    (T_RC),
    .N_BANKS (N_BANKS),
    .ADDR_W  (ADDR_W),
    .AP_BIT  (AP_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .user_req  (user_req),
    .user_gnt  (user_gnt),
    .bank_open (bank_open),
    .sdr_cke   (sdr_cke),
    .sdr_cs_n  (sdr_cs_n),
    .sdr_ras_n (sdr_ras_n),
    .sdr_cas_n (sdr_cas_n),
    .sdr_we_n  (sdr_we_n),
    .sdr_addr  (sdr_addr)
);

// File: tb/ref_sched_test.sv
`timescale 1ns/1ps
module ref_sched_test;
    localparam int T_REF = 640;
    localparam int REF_COUNT = 8;
    localparam int T_RP = 3;
    localparam int T_RC = 6;
    localparam int PMAX = 8;
    localparam int NB = 4;
    localparam int AW = 13;
    localparam int IV = T_REF / REF_COUNT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst_mode = 1'b0;
    logic user_req = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic user_gnt, sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;
    logic [AW-1:0] sdr_addr;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    int n_ref = 0;
    int n_pre = 0;
    int bad_enc = 0;
    int ref_at [0:63];
    int pre_at [0:63];
    bit done = 1'b0;

    ref_sched #(
        .T_REF(T_REF), .REF_COUNT(REF_COUNT), .T_RP(T_RP), .T_RC(T_RC),
        .POSTPONE_MAX(PMAX), .N_BANKS(NB), .ADDR_W(AW), .AP_BIT(10)
    ) uut (
        .clk(clk), .rst(rst), .burst_mode(burst_mode), .user_req(user_req),
        .bank_open(bank_open), .user_gnt(user_gnt), .sdr_cke(sdr_cke),
        .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n),
        .sdr_we_n(sdr_we_n), .sdr_addr(sdr_addr)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Command monitor: logs refresh and precharge cycles, counts bad encodings (R2, R3)
    always @(negedge clk) begin
        if (!rst) begin
            if (!sdr_cke) bad_enc++;
            if (!sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n) begin
                if (sdr_addr != '0) bad_enc++;
                if (n_ref < 64) ref_at[n_ref] = cyc;
                n_ref++;
            end else if (!sdr_cs_n && !sdr_ras_n && sdr_cas_n && !sdr_we_n) begin
                if (sdr_addr != AW'(1 << 10)) bad_enc++;
                if (n_pre < 64) pre_at[n_pre] = cyc;
                n_pre++;
            end else if (!(!sdr_cs_n && sdr_ras_n && sdr_cas_n && sdr_we_n)) begin
                bad_enc++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic restart(input bit mode, input bit req, input logic [NB-1:0] banks);
        @(negedge clk);
        rst = 1'b1;
        burst_mode = mode;
        user_req = req;
        bank_open = banks;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_ref = 0;
        n_pre = 0;
        bad_enc = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        user_req = 1'b1;
        repeat (3) @(negedge clk);
        chk({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0111, "R1", "reset pins NOP",
            int'({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}), 7);
        chk(sdr_cke == 1'b1 && sdr_addr == '0, "R1", "reset cke/addr", int'(sdr_addr), 0);
        chk(user_gnt == 1'b0, "R1", "reset grant", int'(user_gnt), 0);
    endtask

    task automatic t_distributed;
        restart(1'b0, 1'b0, '0);
        wait_cyc(3 * IV + 20);
        chk(n_ref == 3, "R5", "distributed refresh count", n_ref, 3);
        chk(ref_at[0] == IV + 1, "R5", "first refresh cycle", ref_at[0], IV + 1);
        chk(ref_at[2] - ref_at[1] == IV, "R5", "refresh spacing", ref_at[2] - ref_at[1], IV);
        chk(n_pre == 0, "R3", "no precharge with banks closed", n_pre, 0);
        chk(bad_enc == 0, "R2", "command encodings", bad_enc, 0);
    endtask

    task automatic t_precharge;
        restart(1'b0, 1'b0, 4'b0010);
        wait_cyc(2 * IV + 20);
        chk(n_pre == 2, "R3", "precharge count", n_pre, 2);
        chk(pre_at[0] == IV + 1, "R3", "precharge cycle", pre_at[0], IV + 1);
        chk(ref_at[0] - pre_at[0] == T_RP, "R4", "precharge to refresh gap", ref_at[0] - pre_at[0], T_RP);
        chk(ref_at[1] - pre_at[1] == T_RP, "R4", "second gap", ref_at[1] - pre_at[1], T_RP);
        chk(bad_enc == 0, "R3", "precharge encoding", bad_enc, 0);
    endtask

    task automatic t_grant_after_ref;
        restart(1'b0, 1'b0, '0);
        wait_cyc(IV + 1);
        user_req = 1'b1;
        chk(user_gnt == 1'b0, "R7", "grant during refresh", int'(user_gnt), 0);
        wait_cyc(IV + T_RC);
        chk(user_gnt == 1'b0, "R7", "grant before tRC", int'(user_gnt), 0);
        wait_cyc(IV + 1 + T_RC);
        chk(user_gnt == 1'b1, "R7", "grant after tRC", int'(user_gnt), 1);
    endtask

    task automatic t_postpone;
        restart(1'b0, 1'b1, '0);
        wait_cyc(PMAX * IV - 1);
        chk(user_gnt == 1'b1, "R8", "grant held before limit", int'(user_gnt), 1);
        chk(n_ref == 0, "R8", "refreshes deferred", n_ref, 0);
        wait_cyc(PMAX * IV);
        chk(user_gnt == 1'b0, "R8", "grant dropped at limit", int'(user_gnt), 0);
        wait_cyc(PMAX * IV + 1 + PMAX * T_RC - 1);
        chk(user_gnt == 1'b0, "R8", "grant low before drain end", int'(user_gnt), 0);
        wait_cyc(PMAX * IV + 1 + PMAX * T_RC);
        chk(user_gnt == 1'b1, "R8", "grant back after drain", int'(user_gnt), 1);
        chk(n_ref == PMAX, "R8", "drained refresh count", n_ref, PMAX);
        chk(ref_at[0] == PMAX * IV + 1, "R8", "first forced refresh", ref_at[0], PMAX * IV + 1);
        chk(ref_at[PMAX-1] - ref_at[0] == (PMAX - 1) * T_RC, "R8", "drain spacing",
            ref_at[PMAX-1] - ref_at[0], (PMAX - 1) * T_RC);
    endtask

    task automatic t_release;
        restart(1'b0, 1'b1, '0);
        wait_cyc(3 * IV + 10);
        chk(n_ref == 0, "R9", "deferred while held", n_ref, 0);
        user_req = 1'b0;
        wait_cyc(3 * IV + 10 + 3 * T_RC + 5);
        chk(n_ref == 3, "R9", "released refresh count", n_ref, 3);
        chk(ref_at[0] == 3 * IV + 11, "R9", "first after release", ref_at[0], 3 * IV + 11);
        chk(ref_at[2] - ref_at[0] == 2 * T_RC, "R9", "release spacing", ref_at[2] - ref_at[0], 2 * T_RC);
    endtask

    task automatic t_burst;
        restart(1'b1, 1'b1, '0);
        wait_cyc(T_REF - 1);
        chk(n_ref == 0, "R6", "no refresh inside period", n_ref, 0);
        chk(user_gnt == 1'b1, "R6", "grant before burst", int'(user_gnt), 1);
        wait_cyc(T_REF);
        chk(user_gnt == 1'b0, "R6", "burst overrides request", int'(user_gnt), 0);
        wait_cyc(T_REF + 1 + REF_COUNT * T_RC + 2);
        chk(n_ref == REF_COUNT, "R6", "burst refresh count", n_ref, REF_COUNT);
        chk(ref_at[0] == T_REF + 1, "R6", "burst start", ref_at[0], T_REF + 1);
        chk(ref_at[1] - ref_at[0] == T_RC, "R6", "burst spacing", ref_at[1] - ref_at[0], T_RC);
        chk(ref_at[REF_COUNT-1] - ref_at[0] == (REF_COUNT - 1) * T_RC, "R6", "burst span",
            ref_at[REF_COUNT-1] - ref_at[0], (REF_COUNT - 1) * T_RC);
        chk(bad_enc == 0, "R2", "burst encodings", bad_enc, 0);
    endtask

    initial begin
        t_reset();
        t_distributed();
        t_precharge();
        t_grant_after_ref();
        t_postpone();
        t_release();
        t_burst();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule